// File: doc/BRIEF.md
# Windowed Register File

This block is the register file of a small load/store core in which software sees 32 logical registers. Only some of the 80 physical registers stand behind those names at any one time. Eight global registers are visible from every window. The remaining logical names resolve through a window pointer into one of four register windows. Each window has an incoming group, a private group and an outgoing group. The outgoing group of window `w` is the same storage as the incoming group of window `w+1`. A caller places arguments in its outgoing registers and the callee finds them in its incoming registers. Results travel back the same way.

A call strobe moves the active window one step deeper, and a return strobe moves it back one step. A per-window valid mask records which windows are in use. Windowing does not wrap around. A call made from the deepest window, or a return made from window 0, leaves the pointer where it is and raises an overflow or underflow pulse. Software or a trap handler uses that pulse to decide what to do. The block has two combinational read ports and one write port that takes effect on the clock edge.

Top module: `rwin_regfile`

## Requirements
- R1: Synchronous active-low reset sets the window pointer to 0, sets the mask to 4'b0001 (bit i stands for window i), clears both flags, and clears every physical register to zero.
- R2: Logical registers 0 to 7 name the same eight global registers in every window.
- R3: In the active window, logical 8 to 15 are the outgoing group, 16 to 23 the private group and 24 to 31 the incoming group. Private registers of different windows are distinct storage.
- R4: A value written to outgoing register 8+k in window w reads back as incoming register 24+k in window w+1. A value written to incoming register 24+k in window w+1 reads back as outgoing register 8+k in window w after the return.
- R5: A call (call_i high, ret_i low) from a window below the last one increments the pointer and sets the mask bit of the new window. Both changes appear in the cycle after the strobe.
- R6: A return (ret_i high, call_i low) from a window above 0 decrements the pointer and clears the mask bit of the window being left. Both changes appear in the cycle after the strobe.
- R7: A call while window 3 is active leaves the pointer and mask unchanged. It drives ovf_o high for exactly the one cycle after the strobe.
- R8: A return while window 0 is active leaves the pointer and mask unchanged. It drives unf_o high for exactly the one cycle after the strobe.
- R9: A write in the same cycle as a call or return goes to the window that was active before the move.
- R10: Reads are combinational. A write made on a clock edge is visible on the read ports in the cycle that follows that edge.
- R11: call_i and ret_i high together leave the pointer and mask unchanged and raise neither flag.
- R12: With wr_en low, no register changes, whatever wr_idx and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 5 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| win_ptr_o | output | 2 | Active window number |
| win_mask_o | output | 4 | Window valid mask, bit i for window i |
| ovf_o | output | 1 | Window overflow pulse |
| unf_o | output | 1 | Window underflow pulse |

## Verification
Read data is due in the same cycle that the index is presented. A write, call or return takes effect at the next rising edge, so its result is due in the following cycle. The overflow and underflow pulses appear in the cycle after the rejected strobe and are gone one cycle later. The driver applies each stimulus just after an edge and records the expected value for the cycle in which it must hold. The monitor compares late in that same cycle, well before the next edge, so every check falls on exactly the due cycle with no slack.

// File: rtl/rwin_pkg.sv
// Package: shared types for the windowed register file.
// Assumes logical register numbers split into a 2-bit group code above
// a group offset; the group code order is fixed by the decode below.
package rwin_pkg;

    // Group a logical register number belongs to, by its upper two bits.
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;

    // Requested movement of the active window for one cycle.
    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_CALL = 2'd1,
        MV_RET  = 2'd2
    } win_move_e;

    // Resolve the two strobes into one movement request.
    function automatic win_move_e move_of(input logic call_s, input logic ret_s);
        win_move_e m;
        case ({call_s, ret_s})
            2'b10:   m = MV_CALL;
            2'b01:   m = MV_RET;
            default: m = MV_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rwin_ptr_ctrl.sv
// Module: window pointer and valid-mask controller.
// Moves the active window one step on call or return, without wrap-around.
// Rejected moves raise a one-cycle overflow or underflow pulse.
// Assumes NUM_WIN >= 2. The reset is synchronous and active low.
module rwin_ptr_ctrl
    import rwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int PW     = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_i,
    input  logic               ret_i,
    output logic [PW-1:0]      ptr_o,
    output logic [NUM_WIN-1:0] mask_o,
    output logic               ovf_o,
    output logic               unf_o
);

    localparam logic [PW-1:0] LAST_WIN = PW'(NUM_WIN - 1);

    win_move_e          move;
    logic               at_last;
    logic               at_first;
    logic [PW-1:0]      ptr_q;
    logic [NUM_WIN-1:0] mask_q;
    logic               ovf_q;
    logic               unf_q;

    // Classify this cycle's request and the pointer's boundary position.
    always_comb begin
        move     = move_of(call_i, ret_i);
        at_last  = (ptr_q == LAST_WIN);
        at_first = (ptr_q == '0);
    end

    // Update the pointer, the mask and the boundary pulses on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mask_q <= NUM_WIN'(1);
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            case (move)
                MV_CALL: begin
                    if (at_last) begin
                        ovf_q <= 1'b1;
                    end else begin
                        ptr_q                <= ptr_q + PW'(1);
                        mask_q[ptr_q + PW'(1)] <= 1'b1;
                    end
                end
                MV_RET: begin
                    if (at_first) begin
                        unf_q <= 1'b1;
                    end else begin
                        ptr_q         <= ptr_q - PW'(1);
                        mask_q[ptr_q] <= 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign ptr_o  = ptr_q;
    assign mask_o = mask_q;
    assign ovf_o  = ovf_q;
    assign unf_o  = unf_q;

endmodule

// File: rtl/rwin_addr_map.sv
// Module: maps a logical register number to a physical register index.
// Layout: globals at 0. The incoming group of window w sits at GRP*(1+2w),
// its private group at GRP*(2+2w) and its outgoing group at GRP*(3+2w).
// Window w's outgoing group is therefore window w+1's incoming group.
// Assumes GRP_SZ is a power of two. Purely combinational.
module rwin_addr_map
    import rwin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int GRP_SZ  = 8,
    localparam int PW     = $clog2(NUM_WIN),
    localparam int GW     = $clog2(GRP_SZ),
    localparam int LW     = GW + 2,
    localparam int NPHYS  = GRP_SZ * (2 + 2 * NUM_WIN),
    localparam int PHW    = $clog2(NPHYS)
) (
    input  logic [LW-1:0]  lidx_i,
    input  logic [PW-1:0]  ptr_i,
    output logic [PHW-1:0] phys_o
);

    localparam int WSTRIDE = 2 * GRP_SZ;

    reg_group_e     grp;
    logic [PHW-1:0] win_base;
    logic [PHW-1:0] grp_base;
    logic [PHW-1:0] offs;

    // Split the logical number into group and offset, and scale the window.
    always_comb begin
        grp      = reg_group_e'(lidx_i[LW-1:GW]);
        offs     = PHW'(lidx_i[GW-1:0]);
        win_base = PHW'(ptr_i) * PHW'(WSTRIDE);
    end

    // Pick the physical base of the group that the number selects.
    always_comb begin
        case (grp)
            GRP_GLOBAL: grp_base = '0;
            GRP_IN:     grp_base = win_base + PHW'(GRP_SZ);
            GRP_LOCAL:  grp_base = win_base + PHW'(2 * GRP_SZ);
            default:    grp_base = win_base + PHW'(3 * GRP_SZ);
        endcase
        phys_o = grp_base + offs;
    end

endmodule

// File: rtl/rwin_storage.sv
// Module: flat physical register array with one write port and N_RD
// combinational read ports addressed by physical index.
// Assumes every index presented is below NPHYS. Synchronous active-low
// reset clears the whole array.
module rwin_storage #(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 80,
    parameter int N_RD   = 2,
    localparam int PHW   = $clog2(NPHYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [PHW-1:0]       waddr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [PHW-1:0]       raddr_i [N_RD],
    output logic [DATA_W-1:0]    rdata_o [N_RD]
);

    logic [DATA_W-1:0] regs_q [NPHYS];

    // Clear on reset, otherwise store the write data at the write index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we_i) begin
            regs_q[waddr_i] <= wdata_i;
        end
    end

    // One combinational read multiplexer for each read port.
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            rdata_o[p] = regs_q[raddr_i[p]];
        end
    end

endmodule

// File: rtl/rwin_regfile.sv
// Module: windowed register file top.
// Ties the window controller, one address map per port and the storage
// array together. A write uses the pointer that holds during its cycle,
// so a write issued with a call or return lands in the old window.
// Assumes NUM_WIN >= 2 and GRP_SZ is a power of two.
module rwin_regfile #(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 32,
    parameter int GRP_SZ  = 8,
    localparam int PW     = $clog2(NUM_WIN),
    localparam int LW     = $clog2(GRP_SZ) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LW-1:0]      rd_a_idx,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [LW-1:0]      rd_b_idx,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [LW-1:0]      wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               call_i,
    input  logic               ret_i,
    output logic [PW-1:0]      win_ptr_o,
    output logic [NUM_WIN-1:0] win_mask_o,
    output logic               ovf_o,
    output logic               unf_o
);

    localparam int NPHYS  = GRP_SZ * (2 + 2 * NUM_WIN);
    localparam int PHW    = $clog2(NPHYS);
    localparam int N_RD   = 2;
    localparam int N_PORT = N_RD + 1;

    logic [PW-1:0]     cur_ptr;
    logic [LW-1:0]     port_lidx [N_PORT];
    logic [PHW-1:0]    port_phys [N_PORT];
    logic [PHW-1:0]    rd_phys   [N_RD];
    logic [DATA_W-1:0] rd_vals   [N_RD];

    rwin_ptr_ctrl #(
        .NUM_WIN (NUM_WIN)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .ptr_o  (cur_ptr),
        .mask_o (win_mask_o),
        .ovf_o  (ovf_o),
        .unf_o  (unf_o)
    );

    // Collect the logical numbers: read ports first, write port last.
    always_comb begin
        port_lidx[0] = rd_a_idx;
        port_lidx[1] = rd_b_idx;
        port_lidx[2] = wr_idx;
    end

    // One address map for each port, all driven by the same pointer.
    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        rwin_addr_map #(
            .NUM_WIN (NUM_WIN),
            .GRP_SZ  (GRP_SZ)
        ) u_map (
            .lidx_i (port_lidx[p]),
            .ptr_i  (cur_ptr),
            .phys_o (port_phys[p])
        );
    end

    // Route the mapped read indices into the storage read ports.
    for (genvar r = 0; r < N_RD; r++) begin : g_rdx
        assign rd_phys[r] = port_phys[r];
    end

    rwin_storage #(
        .DATA_W (DATA_W),
        .NPHYS  (NPHYS),
        .N_RD   (N_RD)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (port_phys[N_RD]),
        .wdata_i (wr_data),
        .raddr_i (rd_phys),
        .rdata_o (rd_vals)
    );

    assign rd_a_data = rd_vals[0];
    assign rd_b_data = rd_vals[1];
    assign win_ptr_o = cur_ptr;

endmodule

// File: rtl/rwin_regfile_chk.sv
// Module: property checker for the windowed register file, bound to the
// top. It watches only the top-level ports.
module rwin_regfile_chk #(
    parameter int NUM_WIN = 4,
    localparam int PW     = $clog2(NUM_WIN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               call_i,
    input logic               ret_i,
    input logic [PW-1:0]      win_ptr_o,
    input logic [NUM_WIN-1:0] win_mask_o,
    input logic               ovf_o,
    input logic               unf_o
);

    localparam logic [PW-1:0] LAST_WIN = PW'(NUM_WIN - 1);

    // R5
    call_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && win_ptr_o != LAST_WIN)
        |=> (win_ptr_o == $past(win_ptr_o) + PW'(1)) && win_mask_o[win_ptr_o]
            && ($countones(win_mask_o) == $countones($past(win_mask_o)) + 1));

    // R6
    ret_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && win_ptr_o != '0)
        |=> (win_ptr_o == $past(win_ptr_o) - PW'(1)) && !win_mask_o[$past(win_ptr_o)]);

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && win_ptr_o == LAST_WIN)
        |=> ovf_o && $stable(win_ptr_o) && $stable(win_mask_o));

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(call_i && !ret_i && win_ptr_o == LAST_WIN));

    // R8
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && win_ptr_o == '0)
        |=> unf_o && $stable(win_ptr_o) && $stable(win_mask_o));

    // R11
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i)
        |=> $stable(win_ptr_o) && $stable(win_mask_o) && !ovf_o && !unf_o);

    // R1
    base_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_mask_o[0]);

endmodule

bind rwin_regfile rwin_regfile_chk #(
    .NUM_WIN (NUM_WIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .win_ptr_o  (win_ptr_o),
    .win_mask_o (win_mask_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
);

// File: tb/rwin_regfile_tb.sv
// Scoreboard bench: driver tasks push expected items for the current
// cycle, and a monitor pops and compares them late in that cycle.
`timescale 1ns/1ps
module rwin_regfile_tb;

    localparam int NW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_idx = '0;
    logic [DW-1:0] rd_a_data;
    logic [4:0]    rd_b_idx = '0;
    logic [DW-1:0] rd_b_data;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          call_i = 1'b0;
    logic          ret_i = 1'b0;
    logic [1:0]    win_ptr_o;
    logic [NW-1:0] win_mask_o;
    logic          ovf_o;
    logic          unf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          kq[$];
    logic [31:0] eq[$];
    string       rq[$];

    always #10 clk = ~clk;

    rwin_regfile u_dut (
        .clk (clk), .rst_n (rst_n),
        .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
        .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
        .call_i (call_i), .ret_i (ret_i),
        .win_ptr_o (win_ptr_o), .win_mask_o (win_mask_o),
        .ovf_o (ovf_o), .unf_o (unf_o)
    );

    function automatic logic [31:0] probe(int k);
        case (k)
            0: return rd_a_data;
            1: return rd_b_data;
            2: return 32'(win_ptr_o);
            3: return 32'(win_mask_o);
            4: return 32'(ovf_o);
            default: return 32'(unf_o);
        endcase
    endfunction

    // Monitor: compare every queued item late in the cycle it was queued.
    initial begin
        forever begin
            @(posedge clk);
            #15;
            while (kq.size() > 0) begin
                int k;
                logic [31:0] e;
                string r;
                k = kq.pop_front();
                e = eq.pop_front();
                r = rq.pop_front();
                checks++;
                if (probe(k) !== e) begin
                    errors++;
                    $display("FAIL %s item %0d actual %h expected %h", r, k, probe(k), e);
                end
            end
        end
    end

    task automatic push(int k, logic [31:0] v, string r);
        kq.push_back(k);
        eq.push_back(v);
        rq.push_back(r);
    endtask

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic look(logic [4:0] ia, logic [31:0] ea, logic [4:0] ib, logic [31:0] eb, string r);
        rd_a_idx = ia;
        rd_b_idx = ib;
        push(0, ea, r);
        push(1, eb, r);
        cyc();
    endtask

    task automatic look_state(int p, int m, int o, int u, string r);
        push(2, 32'(p), r);
        push(3, 32'(m), r);
        push(4, 32'(o), r);
        push(5, 32'(u), r);
        cyc();
    endtask

    task automatic wr(logic [4:0] idx, logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic do_call();
        call_i = 1'b1;
        cyc();
        call_i = 1'b0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1;
        cyc();
        ret_i = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state
        look_state(0, 1, 0, 0, "R1");
        look(5'd5, 32'h0, 5'd20, 32'h0, "R1");

        // R10: writes visible on the next cycle through both read ports
        wr(5'd3, 32'h11);
        wr(5'd8, 32'hA0);
        wr(5'd16, 32'hB0);
        wr(5'd24, 32'hC0);
        look(5'd24, 32'hC0, 5'd3, 32'h11, "R10");
        look(5'd8, 32'hA0, 5'd16, 32'hB0, "R10");

        // R12: disabled write leaves the target unchanged
        wr_idx = 5'd16; wr_data = 32'hFFFF_FFFF;
        cyc();
        look(5'd16, 32'hB0, 5'd3, 32'h11, "R12");

        // R9 + R5: call with a write to outgoing r9 in the same cycle
        call_i = 1'b1; wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h55;
        cyc();
        call_i = 1'b0; wr_en = 1'b0;
        look_state(1, 3, 0, 0, "R5");
        look(5'd24, 32'hA0, 5'd3, 32'h11, "R4 R2");
        look(5'd25, 32'h55, 5'd16, 32'h0, "R9 R3");

        // Callee writes a result and a private value
        wr(5'd24, 32'hD0);
        wr(5'd16, 32'hE0);

        // R9 + R6: return with a write to private r17 in the same cycle
        ret_i = 1'b1; wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h77;
        cyc();
        ret_i = 1'b0; wr_en = 1'b0;
        look_state(0, 1, 0, 0, "R6");
        look(5'd8, 32'hD0, 5'd16, 32'hB0, "R4 R3");
        look(5'd24, 32'hC0, 5'd17, 32'h0, "R3 R9");

        // Re-enter window 1: its private values were kept
        do_call();
        look_state(1, 3, 0, 0, "R5");
        look(5'd16, 32'hE0, 5'd17, 32'h77, "R9 R3");

        do_call();
        do_call();
        look_state(3, 15, 0, 0, "R5");
        look(5'd3, 32'h11, 5'd16, 32'h0, "R2");

        // R7: overflow at the last window
        do_call();
        look_state(3, 15, 1, 0, "R7");
        look_state(3, 15, 0, 0, "R7");

        // R11: both strobes together
        call_i = 1'b1; ret_i = 1'b1;
        cyc();
        call_i = 1'b0; ret_i = 1'b0;
        look_state(3, 15, 0, 0, "R11");

        do_ret();
        look_state(2, 7, 0, 0, "R6");
        do_ret();
        do_ret();
        look_state(0, 1, 0, 0, "R6");

        // R8: underflow at window 0
        do_ret();
        look_state(0, 1, 0, 1, "R8");
        look_state(0, 1, 0, 0, "R8");

        // R1: reset in mid-run clears the state and the registers
        do_call();
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        look_state(0, 1, 0, 0, "R1");
        look(5'd16, 32'h0, 5'd3, 32'h0, "R1");

        cyc();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule